// File: doc/BRIEF.md
# Sequential Squarer by Odd-Number Summation

This block squares a 4-bit unsigned operand without a multiplier. It uses the identity that n squared equals the sum of the first n odd integers. A start pulse captures the operand. The block clears an accumulator and seeds an odd-number register with 1. On each working cycle it adds the odd value into the accumulator, steps the odd value up by 2 and counts the operand down.

When the down-counter is empty, one more cycle raises a single-cycle done pulse. The latency is therefore data dependent: n + 1 cycles, so the fixed overhead k is 1. The 8-bit result stays on the output from done until the next accepted start. While a computation is running the block reports busy and ignores further start requests.

Top module: `sq_odd_accum`

## Requirements
- R1: While rst_n is low at a rising clock edge, the following edge leaves result = 0, done = 0 and busy = 0.
- R2: For every operand n from 0 to 15, result equals n*n in the cycle that done is high, with no overflow of the 8-bit output.
- R3: With start sampled high at edge E0 while idle, done is high after edge E0+n+1 and low after every earlier edge from E0 onward.
- R4: done is high for exactly one cycle per accepted start.
- R5: After done, result keeps its value on every cycle until the next start is accepted.
- R6: A start presented while busy is high is ignored: the operand and the latency of the running computation are unchanged.
- R7: Operand 0 completes one cycle after the start edge with result 0.
- R8: busy is high from the edge that accepts a start until the edge that raises done, and low in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, honoured only while idle |
| operand | input | 4 | Unsigned value to square |
| result | output | 8 | Accumulated square |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Computation in progress |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a running summation. The bench begins a long computation (operand 9) and, a few cycles in, raises start with a different operand (2). It then requires that the square and the latency still belong to 9. A start in the very cycle done is high is also driven, to show it is taken at once and begins a fresh, correctly timed run.

// File: rtl/sq_odd_accum.sv
module sq_odd_accum #(
  parameter int OPW = 4,
  localparam int RESW = 2 * OPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OPW-1:0]  operand,
  output logic [RESW-1:0] result,
  output logic            done,
  output logic            busy
);
  localparam int ODDW  = OPW + 1;
  localparam int MAXV  = (1 << OPW) - 1;
  localparam int MAXSQ = MAXV * MAXV;

  logic [OPW-1:0]  n_q, cnt_q;
  logic [ODDW-1:0] odd_q;
  logic [RESW-1:0] acc_q;
  logic            busy_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= '0;
      cnt_q  <= '0;
      odd_q  <= ODDW'(1);
      acc_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          n_q    <= operand;
          cnt_q  <= operand;
          acc_q  <= '0;
          odd_q  <= ODDW'(1);
          busy_q <= 1'b1;
        end
      end else if (cnt_q != '0) begin
        acc_q <= acc_q + RESW'(odd_q);
        odd_q <= odd_q + ODDW'(2);
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign result = acc_q;
  assign done   = done_q;
  assign busy   = busy_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= RESW'(MAXSQ));

  assert_odd_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> odd_q == {n_q, 1'b1});

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(acc_q));

  assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(n_q));

  assert_busy_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: tb/sq_odd_accum_tb_top.sv
`timescale 1ns/1ps
module sq_odd_accum_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] operand = '0;
  logic [7:0] result;
  logic       done, busy;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sq_odd_accum dut_i (.clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
                      .result(result), .done(done), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_op(input int n);
    int cyc;
    int r;
    operand = 4'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", int'(busy), (n == 0) ? 1 : 1);
    wait_done(cyc);
    chk("R3 latency", cyc, n + 1);
    chk("R2 square", int'(result), n * n);
    chk("R8 busy low at done", int'(busy), 0);
    if (n == 0) chk("R7 zero operand", int'(result), 0);
    r = int'(result);
    @(negedge clk);
    chk("R4 done single cycle", int'(done), 0);
    operand = 4'(15 - n);
    repeat (2) @(negedge clk);
    chk("R5 result held", int'(result), r);
  endtask

  task automatic test_reset;
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset busy", int'(busy), 0);
  endtask

  task automatic test_busy_start;
    int cyc;
    operand = 4'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    operand = 4'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R6 latency kept", cyc + 4, 10);
    chk("R6 result kept", int'(result), 81);
    @(negedge clk);
    chk("R6 no restart", int'(busy), 0);
  endtask

  task automatic test_back_to_back;
    int cyc;
    operand = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R3 first latency", cyc, 4);
    operand = 4'd5;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 restart busy", int'(busy), 1);
    chk("R4 done dropped", int'(done), 0);
    wait_done(cyc);
    chk("R3 second latency", cyc, 6);
    chk("R2 second square", int'(result), 25);
  endtask

  task automatic test_mid_reset;
    operand = 4'd12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 16; n++) run_op(n);
    test_busy_start();
    test_back_to_back();
    test_mid_reset();
    run_op(15);
    finish_run();
  end

  initial begin
    #200000ns;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule